// File: doc/BRIEF.md
# Rotating-Priority Request Arbiter

This block chooses one winner per clock cycle from a bank of request lines. Priority rotates. Each new search begins at the index just above the last winner and wraps past the top index back to zero. The last winner therefore ranks lowest among the active requesters. The winner appears on a registered binary index together with a registered valid flag. The block arbitrates again on every edge, so a requester that keeps its line high does not keep the grant while any other line is active.

A client watches the index and the flag and acts on the grant in the cycle in which it appears. There is no acknowledge path. When every request line is low, the flag drops and the index keeps its last value. The next search then starts just above that held index.

Top module: `rr_arbiter`

## Requirements
- R1: The grant index is `$clog2(NUM_REQ)` bits wide, with a floor of 1 bit: 5 bits for 32 requesters and 1 bit for a single requester.
- R2: While `rst_n` is low at a rising edge, `grant` becomes 0 and `valid` becomes 0. The stored last winner becomes index 0, so with three lines all requesting after reset, the first grant is index 1.
- R3: `grant` and `valid` change only at a rising clock edge. They reflect the request vector sampled at that edge; a change to `req` between edges leaves both outputs unchanged.
- R4: The search order after last winner p is p+1, p+2, … modulo NUM_REQ, ending with p. Any other active requester beats the last winner.
- R5: If the last winner is the only active request line, it wins again at the next edge.
- R6: Inactive indices are skipped. With requests on lines 0 and 2 and a last winner of 0, the grant goes to 2.
- R7: When no request bit is set at an edge, `valid` is 0 after that edge and `grant` keeps its value. The next search starts above that held index.
- R8: With NUM_REQ = 1, `grant` is always 0 and `valid` equals the request bit sampled at the previous edge.
- R9: Whenever `valid` is 1, the request line named by `grant` was set in the vector sampled at the edge that produced it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | NUM_REQ | One request line per client, active high |
| grant | output | max(1, $clog2(NUM_REQ)) | Registered binary index of the current winner |
| valid | output | 1 | Registered flag: 1 when `grant` names a winner |

## Verification
The bound checker tests these properties on every cycle:
- the reset values;
- `valid` tracking whether any request was sampled;
- the granted line having been set in the sampled vector;
- the index holding while all lines are idle;
- a sole last winner keeping the grant.

The rotation order itself, with its wrap point and skipped indices, is shown only by the bench's directed request sequences, which are compared against hand-computed winners. The same applies to the pointer surviving an idle gap, the outputs staying quiet between edges, and the width of the index port.

// File: rtl/rr_arb_pkg.sv
// Package: shared sizing helpers for the rotating-priority arbiter.
// Assumes callers pass a requester count of at least 1.
package rr_arb_pkg;

    // Width of a binary index able to name every requester, never below 1 bit.
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rr_next_pick.sv
// Module: rr_next_pick
// Combinational winner search. Starting one above the last winner, it scans
// the request vector upward with wraparound and reports the first set line.
// The last winner is examined last. It assumes last_idx < NUM_REQ.
module rr_next_pick #(
    parameter int NUM_REQ = 4,
    parameter int GW      = 2
) (
    input  logic [NUM_REQ-1:0] req,
    input  logic [GW-1:0]      last_idx,
    output logic [GW-1:0]      pick_idx,
    output logic               any_req
);

    // Scan from lowest priority to highest so that the highest-priority hit is written last.
    always_comb begin
        pick_idx = last_idx;
        any_req  = |req;
        for (int k = NUM_REQ; k >= 1; k--) begin
            int idx;
            idx = (int'(last_idx) + k) % NUM_REQ;
            if (req[idx]) begin
                pick_idx = GW'(idx);
            end
        end
    end

endmodule

// File: rtl/rr_grant_reg.sv
// Module: rr_grant_reg
// Output and pointer register. It keeps the winning index, which also serves
// as the start point of the next search, and the valid flag. The index is held
// when no line requests. It assumes a synchronous, active-low reset.
module rr_grant_reg #(
    parameter int GW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [GW-1:0] next_idx,
    output logic [GW-1:0] grant_q,
    output logic          valid_q
);

    // Capture a new winner on each edge that has a request; keep the index otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= load;
            if (load) begin
                grant_q <= next_idx;
            end
        end
    end

endmodule

// File: rtl/rr_arbiter.sv
// Module: rr_arbiter (top)
// Rotating-priority arbiter with a registered binary grant and a valid flag.
// It arbitrates again on every edge. It assumes NUM_REQ >= 1, and that req is
// synchronous to clk.
module rr_arbiter #(
    parameter int NUM_REQ = 4
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic [NUM_REQ-1:0]                    req,
    output logic [rr_arb_pkg::idx_bits(NUM_REQ)-1:0] grant,
    output logic                                  valid
);

    localparam int GW = rr_arb_pkg::idx_bits(NUM_REQ);

    logic [GW-1:0] pick_idx;
    logic          any_req;

    rr_next_pick #(
        .NUM_REQ (NUM_REQ),
        .GW      (GW)
    ) pick_i (
        .req      (req),
        .last_idx (grant),
        .pick_idx (pick_idx),
        .any_req  (any_req)
    );

    rr_grant_reg #(
        .GW (GW)
    ) reg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (any_req),
        .next_idx (pick_idx),
        .grant_q  (grant),
        .valid_q  (valid)
    );

endmodule

// File: rtl/rr_arbiter_chk.sv
// Module: rr_arbiter_chk
// Property checker attached to every rr_arbiter instance through bind.
// It observes only the ports of the arbiter.
module rr_arbiter_chk #(
    parameter int NUM_REQ = 4
) (
    input logic                                  clk,
    input logic                                  rst_n,
    input logic [NUM_REQ-1:0]                    req,
    input logic [rr_arb_pkg::idx_bits(NUM_REQ)-1:0] grant,
    input logic                                  valid
);

    logic [NUM_REQ-1:0] req_q;
    logic               live_q;

    // Record the sampled request vector, and whether the previous edge was already out of reset.
    always_ff @(posedge clk) begin
        req_q  <= req;
        live_q <= rst_n;
    end

    // R2
    reset_clears_chk: assert property (@(posedge clk) !rst_n |=> (grant == '0 && !valid));

    // R7
    valid_tracks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (valid == (req_q != '0)));

    // R9
    granted_was_requesting_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && valid) |-> req_q[grant]);

    // R7
    idle_holds_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |=> $stable(grant));

    // R5
    sole_holder_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && valid && req == (NUM_REQ'(1) << grant)) |=> $stable(grant));

endmodule

bind rr_arbiter rr_arbiter_chk #(.NUM_REQ(NUM_REQ)) chk_i (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .grant (grant),
    .valid (valid)
);

// File: tb/rr_arbiter_tb_top.sv
`timescale 1ns/1ps
// Directed bench for rr_arbiter. The main instance has three requesters;
// further instances cover one requester and the width for 32 requesters.
module rr_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] req3 = '0;
    logic       req1 = 1'b0;
    logic [31:0] req32 = '0;
    logic [1:0] grant3;
    logic       valid3;
    logic       grant1;
    logic       valid1;
    logic [4:0] grant32;
    logic       valid32;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2 clk = ~clk;

    rr_arbiter #(.NUM_REQ(3)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req3), .grant(grant3), .valid(valid3));

    rr_arbiter #(.NUM_REQ(1)) dut1_i (
        .clk(clk), .rst_n(rst_n), .req(req1), .grant(grant1), .valid(valid1));

    rr_arbiter #(.NUM_REQ(32)) dut32_i (
        .clk(clk), .rst_n(rst_n), .req(req32), .grant(grant32), .valid(valid32));

    // Record one comparison and report a mismatch.
    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drive a request vector at the falling edge, then sample 1 ns after the next rising edge.
    task automatic step3(input logic [2:0] r);
        @(negedge clk);
        req3 = r;
        @(posedge clk);
        #1;
    endtask

    task automatic expect3(input string tag, input int g, input int v);
        chk({tag, " grant"}, int'(grant3), g);
        chk({tag, " valid"}, int'(valid3), v);
    endtask

    // R2: reset values, and the pointer starting at 0
    task automatic t_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req3 = 3'b000;
        repeat (2) @(posedge clk);
        #1;
        expect3("R2 reset", 0, 0);
        @(negedge clk);
        rst_n = 1'b1;
        step3(3'b111);
        expect3("R2 first grant after reset", 1, 1);
    endtask

    // R4 R5 R6 R7: the fixed rotation sequence on three lines
    task automatic t_rotation();
        step3(3'b110); expect3("R4 prev1 req110", 2, 1);
        step3(3'b010); expect3("R4 prev2 req010", 1, 1);
        step3(3'b011); expect3("R4 wrap prev1 req011", 0, 1);
        step3(3'b001); expect3("R5 sole holder", 0, 1);
        step3(3'b101); expect3("R6 skip idle line", 2, 1);
        step3(3'b100); expect3("R5 sole holder top", 2, 1);
        step3(3'b000); expect3("R7 idle", 2, 0);
        step3(3'b001); expect3("R4 after idle", 0, 1);
    endtask

    // R4: every line requesting rotates 1,2,0 in turn
    task automatic t_full_load();
        step3(3'b111); expect3("R4 full load a", 1, 1);
        step3(3'b111); expect3("R4 full load b", 2, 1);
        step3(3'b111); expect3("R4 full load c", 0, 1);
    endtask

    // R7: the pointer survives an idle gap
    task automatic t_idle_pointer();
        step3(3'b010); expect3("R7 setup", 1, 1);
        step3(3'b000); expect3("R7 idle hold a", 1, 0);
        step3(3'b000); expect3("R7 idle hold b", 1, 0);
        step3(3'b111); expect3("R7 search resumes above held index", 2, 1);
    endtask

    // R3: a change between edges does not reach the outputs before the edge
    task automatic t_registered();
        step3(3'b001); expect3("R3 setup", 0, 1);
        @(negedge clk);
        req3 = 3'b000;
        #1;
        expect3("R3 between edges", 0, 1);
        @(posedge clk);
        #1;
        expect3("R3 after edge", 0, 0);
    endtask

    // R8: single requester
    task automatic t_single();
        @(negedge clk); req1 = 1'b1;
        @(posedge clk); #1;
        chk("R8 single grant", int'(grant1), 0);
        chk("R8 single valid high", int'(valid1), 1);
        @(negedge clk); req1 = 1'b0;
        @(posedge clk); #1;
        chk("R8 single valid low", int'(valid1), 0);
        chk("R8 single grant idle", int'(grant1), 0);
    endtask

    // R1: index width, plus one grant at the top of the 32-line range
    task automatic t_width();
        chk("R1 width 32", $bits(grant32), 5);
        chk("R1 width 1", $bits(grant1), 1);
        @(negedge clk); req32 = 32'h8000_0001;
        @(posedge clk); #1;
        chk("R1 R4 wide first grant", int'(grant32), 31);
        @(negedge clk); req32 = '0;
    endtask

    // Finish the run, at most once.
    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_rotation();
        t_full_load();
        t_idle_pointer();
        t_registered();
        t_single();
        t_width();
        t_reset();
        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule